// File: doc/BRIEF.md
# DVMA Translation Control Register Bank

This block holds the software-visible configuration and fault state of an I/O address-translation unit. A processor reaches it over a plain 32-bit word bus with separate write and read strobes and a byte address whose two low bits are ignored. The bus has no wait states. Read data is combinational while the read strobe is high and reads zero otherwise. Each register filters what is written to it through its own keep-mask and its own set of bits that are always one. One register accumulates instead of replacing.

The bank also drives the state that the translation datapath uses: the enable bit, the page-table base, and the lowest device-virtual address of the mapped window. That window ends at the top of the 32-bit space and is selected by a 3-bit size code. When the datapath reports a faulting access, the bank captures the fault syndrome and address and raises a level interrupt. Software lowers the interrupt by reading the fault syndrome, or by writing either fault register. Writes to the two flush registers store the value and emit a one-cycle pulse.

Top module: `dvma_ctl_regs`

## Requirements
- R1: After reset, every register reads zero except these: control reads {VERSION, 24'h0}, the arbitration-enable register (0x2000) reads 0x00000008, fault syndrome (0x1000) reads 0x00800000, arbiter enable (0x1008) reads 0x00000003 and mask ID (0x3018) reads 0x23000000. The interrupt output is low.
- R2: A write to control (0x0000) keeps only the bits under 0x0000001D, and control reads back as that value with VERSION in bits [31:24]. Bit 0 drives `xlate_en`.
- R3: `win_start` equals 0xFFFFFFFF shifted left by (24 + control[4:2]). Code 0 gives 0xFF000000 (16 MB), code 3 gives 0xF8000000 and code 7 gives 0x80000000 (2 GB).
- R4: A write to the page-table base (0x0004) keeps only the bits under 0x07FFFC00. The stored value drives `pt_base`.
- R5: A write to arbiter enable (0x1008) keeps the bits under 0x801F000F, and bit 0 always reads one.
- R6: A write to fault syndrome (0x1000) keeps the bits under 0xFF0FFFFF, forces bit 23 to one and lowers the interrupt in the following cycle.
- R7: A write to fault address (0x1004) stores all 32 bits and lowers the interrupt. A read of fault syndrome also lowers the interrupt. A read of fault address does not lower it.
- R8: A cycle with `fault_valid` high loads the fault syndrome with 0xC0820000, plus bit 18 when `fault_is_read` is high. It loads the fault address with `fault_addr` and raises the interrupt in the following cycle. This capture takes priority over a bus access to the fault registers in the same cycle.
- R9: The four slot-configuration registers at 0x1010, 0x1014, 0x1018 and 0x101C each keep only the bits under 0x00010003. They are independent of one another.
- R10: A write to arbitration enable (0x2000) keeps the bits under 0x001F0000 and always reads with bit 3 set.
- R11: A write to mask ID (0x3018) ORs the written value, masked to 0x00FFFFFF, into the current contents.
- R12: A write to full flush (0x0014) or page flush (0x0018) stores all 32 bits. It raises `flush_all` or `flush_page` for exactly the one cycle after the write edge.
- R13: Any other offset reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; combinational, zero when not reading |
| fault_valid | input | 1 | Fault report from the translation datapath |
| fault_is_read | input | 1 | The faulting access was a read |
| fault_addr | input | 32 | Address of the faulting access |
| irq | output | 1 | Level interrupt |
| xlate_en | output | 1 | Translation enable (control bit 0) |
| win_start | output | 32 | Lowest address of the translated window |
| pt_base | output | 32 | Stored page-table base |
| flush_all | output | 1 | One-cycle pulse after a full-flush write |
| flush_page | output | 1 | One-cycle pulse after a page-flush write |

## Verification
Each masked register is written with all ones, and several registers are also written with all zeros and with alternating patterns. All ones shows which bits are kept. All zeros shows that the forced bits survive a clear. The alternating patterns catch a mask with a wrong bit position. The window decoder is tried with codes 0, 3 and 7, which separate an off-by-one shift from a correct one at both ends. Mask ID is written twice with disjoint bits and once with bits only above the mask, which separates OR-accumulation from replacement. Fault capture is tried as a read and as a write, then with a syndrome write in the same cycle. Together these show that hardware capture wins and that each clearing access lowers the interrupt while a fault-address read does not.

// File: rtl/dvma_regs_pkg.sv
package dvma_regs_pkg;

  localparam int unsigned DW = 32;

  // byte offsets of the implemented registers
  localparam logic [15:0] OFF_CTRL    = 16'h0000;
  localparam logic [15:0] OFF_PTBASE  = 16'h0004;
  localparam logic [15:0] OFF_FLALL   = 16'h0014;
  localparam logic [15:0] OFF_FLPAGE  = 16'h0018;
  localparam logic [15:0] OFF_FSYN    = 16'h1000;
  localparam logic [15:0] OFF_FADDR   = 16'h1004;
  localparam logic [15:0] OFF_ARBMSK  = 16'h1008;
  localparam logic [15:0] OFF_SLOT0   = 16'h1010;
  localparam logic [15:0] OFF_ARBON   = 16'h2000;
  localparam logic [15:0] OFF_MASKID  = 16'h3018;

  // keep-masks and forced-one bits
  localparam logic [DW-1:0] KEEP_CTRL   = 32'h0000_001D;
  localparam logic [DW-1:0] KEEP_PTBASE = 32'h07FF_FC00;
  localparam logic [DW-1:0] KEEP_FSYN   = 32'hFF0F_FFFF;
  localparam logic [DW-1:0] ONE_FSYN    = 32'h0080_0000;
  localparam logic [DW-1:0] KEEP_ARBMSK = 32'h801F_000F;
  localparam logic [DW-1:0] ONE_ARBMSK  = 32'h0000_0001;
  localparam logic [DW-1:0] KEEP_SLOT   = 32'h0001_0003;
  localparam logic [DW-1:0] KEEP_ARBON  = 32'h001F_0000;
  localparam logic [DW-1:0] ONE_ARBON   = 32'h0000_0008;
  localparam logic [DW-1:0] KEEP_MASKID = 32'h00FF_FFFF;

  // reset values
  localparam logic [DW-1:0] RST_FSYN   = 32'h0080_0000;
  localparam logic [DW-1:0] RST_ARBMSK = 32'h0000_0003;
  localparam logic [DW-1:0] RST_ARBON  = 32'h0000_0008;
  localparam logic [DW-1:0] RST_MASKID = 32'h2300_0000;

  // syndrome loaded on a datapath fault: error, late error, forced bit, address valid
  localparam logic [DW-1:0] FAULT_SYN  = 32'hC082_0000;
  localparam logic [DW-1:0] FAULT_RDB  = 32'h0004_0000;

endpackage

// File: rtl/dvma_rst_sync.sv
module dvma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dvma_win_decode.sv
module dvma_win_decode #(
  parameter int unsigned MIN_LOG2 = 24,
  parameter int unsigned CODE_W   = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [31:0]       start
);
  localparam int unsigned SHW = $clog2(MIN_LOG2 + (1 << CODE_W));

  logic [SHW-1:0] shamt;

  always_comb begin
    shamt = SHW'(MIN_LOG2) + SHW'(code);
    start = 32'hFFFF_FFFF << shamt;
  end
endmodule

// File: rtl/dvma_irq_ctrl.sv
module dvma_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q, irq_d, irq_en;

  always_comb begin
    irq_en = set_i | clr_i;
    irq_d  = set_i;        // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dvma_ctl_regs.sv
module dvma_ctl_regs #(
  parameter int unsigned ADDR_W  = 14,
  parameter logic [7:0]  VERSION = 8'h05,
  parameter int unsigned N_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              fault_valid,
  input  logic              fault_is_read,
  input  logic [31:0]       fault_addr,
  output logic              irq,
  output logic              xlate_en,
  output logic [31:0]       win_start,
  output logic [31:0]       pt_base,
  output logic              flush_all,
  output logic              flush_page
);
  import dvma_regs_pkg::*;

  localparam int unsigned WI_W = ADDR_W - 2;

  logic rst_ns;
  logic [WI_W-1:0] widx;

  // address hits
  logic hit_ctrl, hit_ptb, hit_fla, hit_flp, hit_fsyn, hit_fadr;
  logic hit_arbm, hit_arbo, hit_mid;
  logic [N_SLOTS-1:0] hit_slot;

  // register state
  logic [4:0]  ctrl_q,  ctrl_d;
  logic [31:0] ptb_q,   ptb_d;
  logic [31:0] fla_q,   fla_d;
  logic [31:0] flp_q,   flp_d;
  logic [31:0] fsyn_q,  fsyn_d;
  logic [31:0] fadr_q,  fadr_d;
  logic [31:0] arbm_q,  arbm_d;
  logic [31:0] arbo_q,  arbo_d;
  logic [31:0] mid_q,   mid_d;
  logic [31:0] slot_q [N_SLOTS];
  logic        pls_a_q, pls_p_q;

  // clock enables
  logic en_ctrl, en_ptb, en_fla, en_flp, en_fsyn, en_fadr, en_arbm, en_arbo, en_mid;
  logic irq_clr;

  dvma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    hit_ctrl = (widx == OFF_CTRL[ADDR_W-1:2]);
    hit_ptb  = (widx == OFF_PTBASE[ADDR_W-1:2]);
    hit_fla  = (widx == OFF_FLALL[ADDR_W-1:2]);
    hit_flp  = (widx == OFF_FLPAGE[ADDR_W-1:2]);
    hit_fsyn = (widx == OFF_FSYN[ADDR_W-1:2]);
    hit_fadr = (widx == OFF_FADDR[ADDR_W-1:2]);
    hit_arbm = (widx == OFF_ARBMSK[ADDR_W-1:2]);
    hit_arbo = (widx == OFF_ARBON[ADDR_W-1:2]);
    hit_mid  = (widx == OFF_MASKID[ADDR_W-1:2]);
  end

  // next-state
  always_comb begin
    en_ctrl = wr_en & hit_ctrl;
    en_ptb  = wr_en & hit_ptb;
    en_fla  = wr_en & hit_fla;
    en_flp  = wr_en & hit_flp;
    en_arbm = wr_en & hit_arbm;
    en_arbo = wr_en & hit_arbo;
    en_mid  = wr_en & hit_mid;
    en_fsyn = fault_valid | (wr_en & hit_fsyn);
    en_fadr = fault_valid | (wr_en & hit_fadr);

    ctrl_d = wdata[4:0] & KEEP_CTRL[4:0];
    ptb_d  = wdata & KEEP_PTBASE;
    fla_d  = wdata;
    flp_d  = wdata;
    arbm_d = (wdata & KEEP_ARBMSK) | ONE_ARBMSK;
    arbo_d = (wdata & KEEP_ARBON) | ONE_ARBON;
    mid_d  = mid_q | (wdata & KEEP_MASKID);

    if (fault_valid) begin
      fsyn_d = FAULT_SYN | (fault_is_read ? FAULT_RDB : 32'h0);
      fadr_d = fault_addr;
    end else begin
      fsyn_d = (wdata & KEEP_FSYN) | ONE_FSYN;
      fadr_d = wdata;
    end

    irq_clr = (wr_en & (hit_fsyn | hit_fadr)) | (rd_en & hit_fsyn);
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q  <= '0;
      ptb_q   <= '0;
      fla_q   <= '0;
      flp_q   <= '0;
      fsyn_q  <= RST_FSYN;
      fadr_q  <= '0;
      arbm_q  <= RST_ARBMSK;
      arbo_q  <= RST_ARBON;
      mid_q   <= RST_MASKID;
      pls_a_q <= 1'b0;
      pls_p_q <= 1'b0;
    end else begin
      if (en_ctrl) ctrl_q <= ctrl_d;
      if (en_ptb)  ptb_q  <= ptb_d;
      if (en_fla)  fla_q  <= fla_d;
      if (en_flp)  flp_q  <= flp_d;
      if (en_fsyn) fsyn_q <= fsyn_d;
      if (en_fadr) fadr_q <= fadr_d;
      if (en_arbm) arbm_q <= arbm_d;
      if (en_arbo) arbo_q <= arbo_d;
      if (en_mid)  mid_q  <= mid_d;
      pls_a_q <= en_fla;
      pls_p_q <= en_flp;
    end
  end

  // per-slot configuration registers
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam logic [15:0] SOFF = OFF_SLOT0 + 16'(4 * s);
    logic en_s;
    logic [31:0] slot_d;

    always_comb begin
      hit_slot[s] = (widx == SOFF[ADDR_W-1:2]);
      en_s        = wr_en & hit_slot[s];
      slot_d      = wdata & KEEP_SLOT;
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)   slot_q[s] <= '0;
      else if (en_s) slot_q[s] <= slot_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_ctrl) rdata = {VERSION, 19'h0, ctrl_q};
      if (hit_ptb)  rdata = ptb_q;
      if (hit_fla)  rdata = fla_q;
      if (hit_flp)  rdata = flp_q;
      if (hit_fsyn) rdata = fsyn_q;
      if (hit_fadr) rdata = fadr_q;
      if (hit_arbm) rdata = arbm_q;
      if (hit_arbo) rdata = arbo_q;
      if (hit_mid)  rdata = mid_q;
      for (int s = 0; s < N_SLOTS; s++)
        if (hit_slot[s]) rdata = slot_q[s];
    end
  end

  dvma_irq_ctrl u_irq (
    .clk   (clk),
    .rst_n (rst_ns),
    .set_i (fault_valid),
    .clr_i (irq_clr),
    .irq_o (irq)
  );

  dvma_win_decode #(.MIN_LOG2(24), .CODE_W(3)) u_win (
    .code  (ctrl_q[4:2]),
    .start (win_start)
  );

  assign xlate_en   = ctrl_q[0];
  assign pt_base    = ptb_q;
  assign flush_all  = pls_a_q;
  assign flush_page = pls_p_q;

endmodule

// File: rtl/dvma_ctl_regs_chk.sv
module dvma_ctl_regs_chk #(
  parameter int unsigned ADDR_W  = 14,
  parameter logic [7:0]  VERSION = 8'h05
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              fault_valid,
  input logic              irq,
  input logic [31:0]       win_start,
  input logic              flush_all,
  input logic              flush_page
);
  logic [ADDR_W-3:0] wi;
  assign wi = addr[ADDR_W-1:2];

  AST_CTRL_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wi == 0) |-> (rdata[31:24] == VERSION && rdata[23:5] == 0)); // R2

  AST_WIN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start[31] && win_start[23:0] == 0 && $onehot(~win_start + 32'd1))); // R3

  AST_ARBMSK_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wi == 12'h402) |-> rdata[0]); // R5

  AST_FAULT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> irq); // R8

  AST_SYN_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wi == 12'h400 && !fault_valid) |=> !irq); // R7

  AST_ARBON_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wi == 12'h800) |-> (rdata[3] && (rdata & ~32'h001F_0008) == 0)); // R10

  AST_FLUSH_ALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(wr_en && wi == 12'h005)); // R12

  AST_FLUSH_PAGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_page |-> $past(wr_en && wi == 12'h006)); // R12
endmodule

bind dvma_ctl_regs dvma_ctl_regs_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .rdata       (rdata),
  .fault_valid (fault_valid),
  .irq         (irq),
  .win_start   (win_start),
  .flush_all   (flush_all),
  .flush_page  (flush_page)
);

// File: tb/sim_dvma_ctl_regs.sv
`timescale 1ns/1ps
module sim_dvma_ctl_regs;
  localparam logic [7:0] VER = 8'h05;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fault_valid = 1'b0, fault_is_read = 1'b0;
  logic [31:0] fault_addr = '0;
  logic        irq, xlate_en, flush_all, flush_page;
  logic [31:0] win_start, pt_base;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  dvma_ctl_regs #(.ADDR_W(14), .VERSION(VER), .N_SLOTS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fault_valid(fault_valid),
    .fault_is_read(fault_is_read), .fault_addr(fault_addr), .irq(irq),
    .xlate_en(xlate_en), .win_start(win_start), .pt_base(pt_base),
    .flush_all(flush_all), .flush_page(flush_page)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [13:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 ctrl",   14'h0000, {VER, 24'h0});
    rd_chk("R1 ptbase", 14'h0004, 32'h0);
    rd_chk("R1 fsyn",   14'h1000, 32'h0080_0000);
    rd_chk("R1 arbmsk", 14'h1008, 32'h0000_0003);
    rd_chk("R1 arbon",  14'h2000, 32'h0000_0008);
    rd_chk("R1 maskid", 14'h3018, 32'h2300_0000);
    rd_chk("R1 slot2",  14'h1018, 32'h0);
    check("R3 reset window", win_start, 32'hFF00_0000);
  endtask

  task automatic t_ctrl;
    wr(14'h0000, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl ones", 14'h0000, {VER, 24'h00001D});
    check("R2 xlate_en", {31'h0, xlate_en}, 32'h1);
    check("R3 code7", win_start, 32'h8000_0000);
    wr(14'h0000, 32'h0000_000C);
    check("R3 code3", win_start, 32'hF800_0000);
    check("R2 xlate_en off", {31'h0, xlate_en}, 32'h0);
    wr(14'h0000, 32'hAAAA_AAA2);
    rd_chk("R2 ctrl alt", 14'h0000, {VER, 24'h000000});
    check("R3 code0", win_start, 32'hFF00_0000);
  endtask

  task automatic t_base_arb;
    wr(14'h0004, 32'hFFFF_FFFF);
    rd_chk("R4 base", 14'h0004, 32'h07FF_FC00);
    check("R4 pt_base", pt_base, 32'h07FF_FC00);
    wr(14'h1008, 32'h0000_0000);
    rd_chk("R5 arb zeros", 14'h1008, 32'h0000_0001);
    wr(14'h1008, 32'hFFFF_FFFF);
    rd_chk("R5 arb ones", 14'h1008, 32'h801F_000F);
    wr(14'h2000, 32'h0000_0000);
    rd_chk("R10 arbon zeros", 14'h2000, 32'h0000_0008);
    wr(14'h2000, 32'hFFFF_FFFF);
    rd_chk("R10 arbon ones", 14'h2000, 32'h001F_0008);
  endtask

  task automatic t_slots;
    wr(14'h1010, 32'hFFFF_FFFF);
    wr(14'h1014, 32'h5555_5555);
    wr(14'h101C, 32'hAAAA_AAAA);
    rd_chk("R9 slot0", 14'h1010, 32'h0001_0003);
    rd_chk("R9 slot1", 14'h1014, 32'h0001_0001);
    rd_chk("R9 slot2", 14'h1018, 32'h0000_0000);
    rd_chk("R9 slot3", 14'h101C, 32'h0000_0002);
  endtask

  task automatic t_maskid;
    wr(14'h3018, 32'h0000_0011);
    rd_chk("R11 or1", 14'h3018, 32'h2300_0011);
    wr(14'h3018, 32'h0000_0100);
    rd_chk("R11 or2", 14'h3018, 32'h2300_0111);
    wr(14'h3018, 32'hFF00_0000);
    rd_chk("R11 upper ignored", 14'h3018, 32'h2300_0111);
  endtask

  task automatic t_flush;
    @(negedge clk);
    wr_en = 1'b1; addr = 14'h0014; wdata = 32'h1234_5678;
    @(posedge clk); #1;
    check("R12 flush_all high", {31'h0, flush_all}, 32'h1);
    check("R12 flush_page quiet", {31'h0, flush_page}, 32'h0);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    check("R12 flush_all one cycle", {31'h0, flush_all}, 32'h0);
    rd_chk("R12 flush_all data", 14'h0014, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b1; addr = 14'h0018; wdata = 32'hCAFE_F00D;
    @(posedge clk); #1;
    check("R12 flush_page high", {31'h0, flush_page}, 32'h1);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    check("R12 flush_page one cycle", {31'h0, flush_page}, 32'h0);
    rd_chk("R12 flush_page data", 14'h0018, 32'hCAFE_F00D);
  endtask

  task automatic fault(input logic is_rd, input logic [31:0] fa);
    @(negedge clk);
    fault_valid = 1'b1; fault_is_read = is_rd; fault_addr = fa;
    @(posedge clk);
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic t_fault;
    fault(1'b1, 32'hDEAD_B000);
    check("R8 irq raised", {31'h0, irq}, 32'h1);
    rd_chk("R8 fault addr", 14'h1004, 32'hDEAD_B000);
    check("R7 addr read keeps irq", {31'h0, irq}, 32'h1);
    rd_chk("R8 syn read", 14'h1000, 32'hC086_0000);
    check("R7 syn read clears", {31'h0, irq}, 32'h0);
    fault(1'b0, 32'h0000_3000);
    rd_chk("R8 syn write", 14'h1000, 32'hC082_0000);
    fault(1'b0, 32'h0000_4000);
    wr(14'h1004, 32'h7777_0000);
    check("R7 addr write clears", {31'h0, irq}, 32'h0);
    rd_chk("R7 addr stored", 14'h1004, 32'h7777_0000);
    fault(1'b1, 32'h0000_5000);
    wr(14'h1000, 32'h0000_0000);
    check("R6 syn write clears", {31'h0, irq}, 32'h0);
    rd_chk("R6 syn zeros", 14'h1000, 32'h0080_0000);
    wr(14'h1000, 32'hFFFF_FFFF);
    rd_chk("R6 syn ones", 14'h1000, 32'hFF8F_FFFF);
    // capture beats a same-cycle syndrome write
    @(negedge clk);
    fault_valid = 1'b1; fault_is_read = 1'b0; fault_addr = 32'h0000_6000;
    wr_en = 1'b1; addr = 14'h1000; wdata = 32'h0000_0000;
    @(posedge clk);
    @(negedge clk);
    fault_valid = 1'b0; wr_en = 1'b0;
    check("R8 priority irq", {31'h0, irq}, 32'h1);
    rd_chk("R8 priority syn", 14'h1000, 32'hC082_0000);
  endtask

  task automatic t_unimpl;
    wr(14'h0008, 32'hFFFF_FFFF);
    wr(14'h1200, 32'hFFFF_FFFF);
    rd_chk("R13 hole 0008", 14'h0008, 32'h0);
    rd_chk("R13 hole 1200", 14'h1200, 32'h0);
    rd_chk("R13 base unchanged", 14'h0004, 32'h07FF_FC00);
    rd_chk("R13 maskid unchanged", 14'h3018, 32'h2300_0111);
    check("R13 no flush", {30'h0, flush_all, flush_page}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_ctrl;
    t_base_arb;
    t_slots;
    t_maskid;
    t_flush;
    t_fault;
    t_unimpl;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule